// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers ninety-six interrupt lines, arranged as three 32-bit banks, into a single interrupt request for a processor. Each line has an enable bit and a mask bit. A line whose pending bit is set, whose enable bit is 1 and whose mask bit is 0 is active. The request output is high while any line is active. A vector register names the lowest-numbered active line, so the handler can dispatch without scanning the banks.

Line 0 is the external non-maskable-style input. Its trigger condition can be set to one of four types, and once it fires it stays latched until software acknowledges it. Lines 1 to 95 are level-sensitive. Their pending bits show the input lines as sampled one clock earlier. The vector reads zero both when line 0 is the winner and when nothing is active. Handler software uses pending bit 0 to tell these two cases apart. All access goes through a single-cycle 32-bit register port: writes are strobed, and reads are combinational from the address.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Byte offsets: vector 0x00, protection 0x08, trigger control 0x0C, pending bank n 0x10+4n, fast-pending bank n 0x20+4n, enable bank n 0x40+4n, mask bank n 0x50+4n (n = 0..2). Line k sits in bank k/32 at bit k%32. Any other address reads zero.
- R2: After reset, every register reads zero and `irq_o` is low.
- R3: For lines 1..95, the pending bit equals the input as sampled at the previous clock edge. Writing to those pending bits has no effect.
- R4: Bits [1:0] of the trigger control select the condition for line 0: 0 = input low, 1 = input high, 2 = falling edge, 3 = rising edge. Edges are judged against the input sampled at the previous edge. A met condition sets pending bit 0 at the next edge.
- R5: Pending bit 0 stays set until a write with bit 0 = 1 reaches pending bank 0. If the trigger condition is met in the same cycle as that write, the bit stays set.
- R6: A line is active when its pending bit is 1, its enable bit is 1 and its mask bit is 0. `irq_o` is the OR of all active lines.
- R7: The vector register reads 4 × (lowest active line number), so bits [1:0] are zero. It reads 0 when no line is active.
- R8: Enable and mask banks store all 32 bits and read them back. Protection stores bit 0 only. Trigger control stores bits [1:0] only. All other bits of these two registers read zero.
- R9: The fast-pending banks always read zero, and writes to them are ignored.
- R10: Writes to the vector register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Interrupt lines, bit k is line k |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Some properties are checked on every cycle by assertions. The encoder's choice must be an active line with no lower-numbered active line below it. A latched line 0 must survive any cycle without an acknowledge. A rising edge on line 0 in rising mode must latch it. A raised request must always come with a valid encoder choice. The protection bit must only change on its own write. Other behaviours can only be shown by the bench scenarios, which compare against a reference model on every clock. These include the four trigger types, the acknowledge that loses to a retrigger, the pending bits of level lines ignoring write-one-to-clear, the fast-pending banks reading zero, and the vector value changing as lines are masked or disabled.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
   typedef enum logic [1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_RISE = 2'd3
   } trig_e;

   localparam int OFS_VECTOR = 'h00;
   localparam int OFS_PROT   = 'h08;
   localparam int OFS_TRIG   = 'h0C;
   localparam int OFS_PEND   = 'h10;
   localparam int OFS_FAST   = 'h20;
   localparam int OFS_EN     = 'h40;
   localparam int OFS_MASK   = 'h50;
   localparam int BANK_STEP  = 4;
   localparam int MAX_BANKS  = 4;
endpackage

// File: rtl/ivc_prio_enc.sv
`timescale 1ns/1ps
module ivc_prio_enc #(
   parameter int N  = 96,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end

   always_comb begin
      // R7
      pick_set_chk: assert (!found_o || req_i[idx_o]);
      // R7
      pick_lowest_chk: assert (!found_o || ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
   end
endmodule

// File: rtl/ivc_bank_pend.sv
`timescale 1ns/1ps
module ivc_bank_pend
   import ivc_pkg::*;
#(
   parameter int W       = 32,
   parameter bit HAS_NMI = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   input  trig_e        trig_i,
   input  logic         clr_i,
   output logic [W-1:0] pend_o
);
   generate
      if (HAS_NMI) begin : g_nmi
         logic         prev_q, nmi_q, hit, armed_q;
         logic [W-1:1] lvl_q;

         always_comb begin
            unique case (trig_i)
               TRIG_LOW:  hit = ~src_i[0];
               TRIG_HIGH: hit = src_i[0];
               TRIG_FALL: hit = prev_q & ~src_i[0];
               default:   hit = ~prev_q & src_i[0];
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q  <= 1'b0;
               nmi_q   <= 1'b0;
               armed_q <= 1'b0;
               lvl_q   <= '0;
            end else begin
               prev_q  <= src_i[0];
               armed_q <= 1'b1;
               lvl_q   <= src_i[W-1:1];
               if (hit)        nmi_q <= 1'b1;
               else if (clr_i) nmi_q <= 1'b0;
            end
         end

         assign pend_o = {lvl_q, nmi_q};

         // R5
         nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (nmi_q && !clr_i) |=> nmi_q);
         // R4
         nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && trig_i == TRIG_RISE && $rose(src_i[0])) |=> nmi_q);
      end else begin : g_lvl
         logic [W-1:0] lvl_q;
         logic         unused_ok;
         assign unused_ok = ^{trig_i, clr_i};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= src_i;
         end

         assign pend_o = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
   import ivc_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int BANK_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] src_i,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        irq_o
);
   localparam int NUM_SRC = NUM_BANKS * BANK_W;
   localparam int IDX_W   = $clog2(NUM_SRC);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("irq_vec_ctrl: NUM_BANKS out of range");
      end
      if (BANK_W != DATA_W) begin : g_bad_width
         $error("irq_vec_ctrl: BANK_W must equal DATA_W");
      end
      if (IDX_W + 2 > DATA_W) begin : g_bad_vec
         $error("irq_vec_ctrl: vector does not fit the data width");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_q, mask_q, pend, active;
   logic               prot_q;
   trig_e              trig_q;
   logic               clr_nmi, found;
   logic [IDX_W-1:0]   idx;
   logic [DATA_W-1:0]  vec_word;

   assign clr_nmi = bus_wr && (bus_addr == ADDR_W'(OFS_PEND)) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '0;
         prot_q <= 1'b0;
         trig_q <= TRIG_LOW;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(OFS_PROT)) prot_q <= bus_wdata[0];
         if (bus_addr == ADDR_W'(OFS_TRIG)) trig_q <= trig_e'(bus_wdata[1:0]);
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_EN + BANK_STEP * b))
               en_q[b*BANK_W +: BANK_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_MASK + BANK_STEP * b))
               mask_q[b*BANK_W +: BANK_W] <= bus_wdata;
         end
      end
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         ivc_bank_pend #(
            .W       (BANK_W),
            .HAS_NMI (b == 0)
         ) u_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[b*BANK_W +: BANK_W]),
            .trig_i (trig_q),
            .clr_i  (clr_nmi),
            .pend_o (pend[b*BANK_W +: BANK_W])
         );
      end
   endgenerate

   assign active = pend & en_q & ~mask_q;
   assign irq_o  = |active;

   ivc_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_enc (
      .req_i   (active),
      .found_o (found),
      .idx_o   (idx)
   );

   assign vec_word = found ? (DATA_W'(idx) << 2) : '0;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_VECTOR)) bus_rdata = vec_word;
      if (bus_addr == ADDR_W'(OFS_PROT))   bus_rdata = {{(DATA_W-1){1'b0}}, prot_q};
      if (bus_addr == ADDR_W'(OFS_TRIG))   bus_rdata = {{(DATA_W-2){1'b0}}, trig_q};
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(OFS_PEND + BANK_STEP * b)) bus_rdata = pend[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(OFS_EN + BANK_STEP * b))   bus_rdata = en_q[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(OFS_MASK + BANK_STEP * b)) bus_rdata = mask_q[b*BANK_W +: BANK_W];
      end
   end

   // R6
   irq_has_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (found && active[idx]));
   // R8
   prot_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(OFS_PROT)) |=> $stable(prot_q));
endmodule

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] src = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   always #5 clk = ~clk;

   irq_vec_ctrl dut (
      .clk (clk), .rst_n (rst_n), .src_i (src), .bus_addr (addr),
      .bus_wr (wr), .bus_wdata (wdata), .bus_rdata (rdata), .irq_o (irq)
   );

   int vectors = 0, miscompares = 0;
   bit cmp_on = 1'b0;

   // behavioural reference model
   logic [95:0] m_pend = '0, m_en = '0, m_mask = '0;
   logic        m_prot = 1'b0, m_prev = 1'b0;
   logic [1:0]  m_trig = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend <= '0; m_en <= '0; m_mask <= '0;
         m_prot <= 1'b0; m_prev <= 1'b0; m_trig <= '0;
      end else begin
         logic hit;
         case (m_trig)
            2'd0: hit = !src[0];
            2'd1: hit = src[0];
            2'd2: hit = m_prev && !src[0];
            default: hit = !m_prev && src[0];
         endcase
         m_prev <= src[0];
         m_pend[95:1] <= src[95:1];
         if (hit) m_pend[0] <= 1'b1;
         else if (wr && addr == 8'h10 && wdata[0]) m_pend[0] <= 1'b0;
         if (wr) begin
            if (addr == 8'h08) m_prot <= wdata[0];
            if (addr == 8'h0C) m_trig <= wdata[1:0];
            for (int b = 0; b < 3; b++) begin
               if (addr == 8'(8'h40 + 4 * b)) m_en[b*32 +: 32] <= wdata;
               if (addr == 8'(8'h50 + 4 * b)) m_mask[b*32 +: 32] <= wdata;
            end
         end
      end
   end

   function automatic logic [31:0] exp_read(logic [7:0] a);
      logic [95:0] act;
      logic [31:0] r;
      act = m_pend & m_en & ~m_mask;
      r = '0;
      if (a == 8'h00) begin
         for (int k = 95; k >= 0; k--) if (act[k]) r = 32'(k * 4);
      end
      if (a == 8'h08) r = {31'b0, m_prot};
      if (a == 8'h0C) r = {30'b0, m_trig};
      for (int b = 0; b < 3; b++) begin
         if (a == 8'(8'h10 + 4 * b)) r = m_pend[b*32 +: 32];
         if (a == 8'(8'h40 + 4 * b)) r = m_en[b*32 +: 32];
         if (a == 8'(8'h50 + 4 * b)) r = m_mask[b*32 +: 32];
      end
      return r;
   endfunction

   function automatic string tag_of(logic [7:0] a);
      if (a == 8'h00) return "R7";
      if (a == 8'h08 || a == 8'h0C) return "R8";
      if (a >= 8'h10 && a <= 8'h18) return "R3";
      if (a >= 8'h20 && a <= 8'h28) return "R9";
      if (a >= 8'h40 && a <= 8'h58) return "R8";
      return "R1";
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         vectors++;
         if (rdata !== exp_read(addr)) begin
            miscompares++;
            $display("FAIL %s model addr %h: actual %h expected %h", tag_of(addr), addr, rdata, exp_read(addr));
         end
         vectors++;
         if (irq !== |(m_pend & m_en & ~m_mask)) begin
            miscompares++;
            $display("FAIL R6 model irq: actual %b expected %b", irq, |(m_pend & m_en & ~m_mask));
         end
      end
   end

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1 addr = a;
      #3;
      vectors++;
      if (rdata !== exp) begin
         miscompares++;
         $display("FAIL %s read %h: actual %h expected %h", tag, a, rdata, exp);
      end
   endtask

   task automatic irq_chk(input logic exp, input string tag);
      vectors++;
      if (irq !== exp) begin
         miscompares++;
         $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1 addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1 wr = 1'b0;
   endtask

   task automatic set_src(input int k, input logic v);
      @(posedge clk); #1 src[k] = v;
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog (R2 run): actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      src[0] = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      // R2 reset state
      rd_chk(8'h00, 0, "R2"); rd_chk(8'h08, 0, "R2"); rd_chk(8'h0C, 0, "R2");
      rd_chk(8'h10, 0, "R2"); rd_chk(8'h14, 0, "R2"); rd_chk(8'h40, 0, "R2");
      rd_chk(8'h50, 0, "R2"); irq_chk(1'b0, "R2");
      // R8 storage
      wr_reg(8'h40, 32'hFFFF_FFFF); wr_reg(8'h44, 32'hFFFF_FFFF); wr_reg(8'h48, 32'hFFFF_FFFF);
      rd_chk(8'h44, 32'hFFFF_FFFF, "R8");
      wr_reg(8'h08, 32'hFFFF_FFFF); rd_chk(8'h08, 32'h1, "R8");
      wr_reg(8'h54, 32'hA5A5_A5A5); rd_chk(8'h54, 32'hA5A5_A5A5, "R8");
      wr_reg(8'h54, 32'h0);
      wr_reg(8'h0C, 32'hFFFF_FFFF); rd_chk(8'h0C, 32'h3, "R8");
      // R4 high level with line held high
      wr_reg(8'h0C, 32'h1);
      rd_chk(8'h10, 32'h1, "R4"); rd_chk(8'h00, 32'h0, "R7"); irq_chk(1'b1, "R6");
      // R5 acknowledge loses to retrigger
      wr_reg(8'h10, 32'h1); rd_chk(8'h10, 32'h1, "R5");
      set_src(0, 1'b0);
      wr_reg(8'h10, 32'h1); rd_chk(8'h10, 32'h0, "R5"); irq_chk(1'b0, "R6");
      // R4 rising edge, R5 sticky after line returns low
      wr_reg(8'h0C, 32'h3);
      set_src(0, 1'b1); set_src(0, 1'b0);
      repeat (3) @(posedge clk);
      rd_chk(8'h10, 32'h1, "R5");
      wr_reg(8'h10, 32'h1); rd_chk(8'h10, 32'h0, "R5");
      // R4 falling edge
      wr_reg(8'h0C, 32'h2);
      set_src(0, 1'b1); rd_chk(8'h10, 32'h0, "R4");
      set_src(0, 1'b0); rd_chk(8'h10, 32'h1, "R4");
      wr_reg(8'h10, 32'h1); rd_chk(8'h10, 32'h0, "R5");
      // R4 low level
      wr_reg(8'h0C, 32'h0); rd_chk(8'h10, 32'h1, "R4");
      set_src(0, 1'b1); wr_reg(8'h10, 32'h1); rd_chk(8'h10, 32'h0, "R5");
      // R3 level lines, R7 lowest wins, R6 gating
      set_src(37, 1'b1);
      rd_chk(8'h14, 32'h20, "R3"); rd_chk(8'h00, 32'd148, "R7");
      wr_reg(8'h14, 32'hFFFF_FFFF); rd_chk(8'h14, 32'h20, "R3");
      set_src(70, 1'b1); rd_chk(8'h00, 32'd148, "R7");
      wr_reg(8'h54, 32'h20); rd_chk(8'h00, 32'd280, "R6");
      wr_reg(8'h48, 32'hFFFF_FFBF); rd_chk(8'h00, 32'h0, "R6"); irq_chk(1'b0, "R6");
      rd_chk(8'h18, 32'h40, "R3");
      set_src(95, 1'b1); rd_chk(8'h00, 32'd380, "R7");
      set_src(37, 1'b0); set_src(70, 1'b0); set_src(95, 1'b0);
      rd_chk(8'h14, 32'h0, "R3");
      // R9 fast-pending, R1 bank mapping, R10 vector write
      wr_reg(8'h20, 32'hFFFF_FFFF); rd_chk(8'h20, 32'h0, "R9");
      set_src(3, 1'b1);
      rd_chk(8'h24, 32'h0, "R9"); rd_chk(8'h10, 32'h8, "R1");
      rd_chk(8'h00, 32'd12, "R7"); irq_chk(1'b1, "R6");
      wr_reg(8'h00, 32'hFFFF_FFFF); rd_chk(8'h00, 32'd12, "R10");
      rd_chk(8'h30, 32'h0, "R1"); rd_chk(8'h08, 32'h1, "R8");
      set_src(3, 1'b0);
      repeat (3) @(posedge clk);
      cmp_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule